// File: doc/BRIEF.md
# Trigger-Gated DMA Channel Sequencer

This block sequences a single DMA channel. Once software sets its enable bit, it breaks a block of bytes into bursts and offers each burst on a ready/valid handshake. It can repeat the block a programmed number of times. At the end of the work it either fetches a further descriptor over a second handshake or completes and raises an interrupt.

A burst is normally issued when a transfer request is present. Requests come from a peripheral request line, or they are always present when the software-request flag is set. A trigger mode can add a second condition: a hardware trigger hit, taken from a rising edge on the trigger input. The mode decides which step the hit gates:

- the first burst of every block;
- the first burst of the whole repeated block;
- only the descriptor link fetch;
- every single burst.

A request that arrives without the hit it needs produces no transfer. Bus protocol, addresses and data are outside the block. The burst size and the block byte count are assumed nonzero.

Top module: `dma_trig_seq`

## Requirements
- R1: After reset the channel is idle: busy_o, burst_valid_o, link_valid_o, done_irq_o and trig_ovr_o are all 0. A write of 1 to the enable bit while idle latches the configuration and makes busy_o 1 from the next cycle.
- R2: When the last burst of the last block is accepted and link_en_i is 0, done_irq_o is high for exactly one cycle and busy_o falls in that same cycle.
- R3: Each burst carries min(burst size, bytes remaining in the block) bytes. The bursts of one block sum to the block byte count, so 10 bytes at burst size 4 gives 4, 4, 2.
- R4: Trigger mode 2'b00 gates only the first burst of each block on one trigger hit, and the later bursts of that block need requests only. With a repeat count N, the block runs N+1 times, and each run waits for its own hit.
- R5: Trigger mode 2'b01 gates only the first burst of the whole repeated block, so one hit lets all N+1 blocks complete. When repeat support is disabled by parameter, the mode acts as 2'b00.
- R6: Trigger mode 2'b10 leaves the data bursts ungated, and the link fetch (link_valid_o) is not offered until a trigger hit is pending.
- R7: Trigger mode 2'b11 needs one trigger hit per burst. With the software-request flag set, a burst waits for a hit only. Without it, a burst needs both per_req_i and a hit.
- R8: With the software-request flag clear and per_req_i low, no burst is issued even when a trigger hit is pending.
- R9: At the end of the last block with link_en_i high, a link fetch is offered on link_valid_o. Once it is accepted, the channel restarts from the configuration inputs as they stand at that moment.
- R10: Only a rising edge of trig_i makes a hit, and a held-high level counts once. The hit stays pending until the gated step consumes it. A new edge that arrives while a hit is already pending sets trig_ovr_o, which stays set until the next start.
- R11: A write of 0 to the enable bit lets an outstanding burst or link handshake finish and then idles the channel without done_irq_o. While no handshake is outstanding, the channel idles at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr_i | input | 1 | Write strobe for the enable bit |
| en_wdata_i | input | 1 | Value written to the enable bit |
| trig_mode_i | input | 2 | Trigger mode: 00 block, 01 repeated block, 10 link, 11 burst |
| blk_bytes_i | input | CNT_W | Block byte count |
| burst_len_i | input | BURST_W | Burst size in bytes |
| rpt_cnt_i | input | RPT_W | Extra block repetitions |
| sw_req_i | input | 1 | Software request flag: request always present |
| per_req_i | input | 1 | Peripheral transfer request |
| trig_i | input | 1 | Hardware trigger input, rising-edge sensitive |
| link_en_i | input | 1 | A further descriptor is to be fetched |
| burst_valid_o | output | 1 | Burst offered |
| burst_ready_i | input | 1 | Burst accepted |
| burst_bytes_o | output | CNT_W | Byte count of offered burst |
| link_valid_o | output | 1 | Link fetch offered |
| link_ready_i | input | 1 | Link fetch accepted |
| done_irq_o | output | 1 | Transfer-complete pulse |
| busy_o | output | 1 | Channel enabled and active |
| trig_ovr_o | output | 1 | Sticky trigger overrun |

## Verification
Each trigger mode is run with continuous requests, and the bench counts bursts between trigger pulses. This shows which step a hit unlocks: one block, the whole repetition, only the link fetch, or one burst. Request patterns are then varied with a hit pending: the peripheral request held low, the software flag set, and a trigger held high. These patterns separate request gating from trigger gating and edge detection from level detection. An uneven byte count checks the short final burst. A stalled burst with a disable write pending, and a double trigger edge, exercise abort and overrun.

// File: rtl/dts_pkg.sv
package dts_pkg;

    typedef enum logic [1:0] {
        TM_BLOCK = 2'b00,
        TM_RPT   = 2'b01,
        TM_LINK  = 2'b10,
        TM_BURST = 2'b11
    } trig_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARM,
        S_BURST,
        S_LGATE,
        S_LINK
    } seq_state_e;

    typedef struct packed {
        trig_mode_e mode;
        logic       sw;
    } chan_cfg_t;

    function automatic logic gate_needed(trig_mode_e m, logic rpt_en,
                                         logic first_blk, logic first_rpt);
        case (m)
            TM_BLOCK: return first_blk;
            TM_RPT:   return rpt_en ? first_rpt : first_blk;
            TM_LINK:  return 1'b0;
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/dts_trig.sv
module dts_trig (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic trig_i,
    input  logic consume,
    input  logic clr_ovr,
    output logic pend_o,
    output logic ovr_o
);
    logic trig_d, pend_q, ovr_q, rise;

    assign rise   = trig_i & ~trig_d;
    assign pend_o = pend_q;
    assign ovr_o  = ovr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_d <= 1'b0;
            pend_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            trig_d <= trig_i;
            if (!active)      pend_q <= 1'b0;
            else if (rise)    pend_q <= 1'b1;
            else if (consume) pend_q <= 1'b0;
            if (clr_ovr)
                ovr_q <= 1'b0;
            else if (active && rise && pend_q && !consume)
                ovr_q <= 1'b1;
        end
    end

    // R10: a hit is consumed only when one is pending
    a_r10_consume_pending: assert property (@(posedge clk) disable iff (rst)
        consume |-> pend_q);
    // R10: overrun is sticky until cleared
    a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovr_q && !clr_ovr) |=> ovr_q);

endmodule

// File: rtl/dts_count.sv
module dts_count #(
    parameter int CNT_W   = 16,
    parameter int BURST_W = 8,
    parameter int RPT_W   = 8,
    parameter bit RPT_EN  = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [CNT_W-1:0]   blk_bytes,
    input  logic [BURST_W-1:0] burst_len,
    input  logic [RPT_W-1:0]   rpt_cnt,
    input  logic               take,
    output logic [CNT_W-1:0]   beat_o,
    output logic               last_o,
    output logic               rpt_zero_o
);
    logic [CNT_W-1:0] bytes_q, blk_q, burst_q;

    assign burst_q = CNT_W'(burst_len_q);
    logic [BURST_W-1:0] burst_len_q;

    assign last_o = (bytes_q <= burst_q);
    assign beat_o = last_o ? bytes_q : burst_q;

    generate
        if (RPT_EN) begin : g_rpt
            logic [RPT_W-1:0] rpt_q;
            assign rpt_zero_o = (rpt_q == '0);
            always_ff @(posedge clk) begin
                if (rst)                              rpt_q <= '0;
                else if (load)                        rpt_q <= rpt_cnt;
                else if (take && last_o && rpt_q != '0) rpt_q <= rpt_q - 1'b1;
            end
        end else begin : g_norpt
            assign rpt_zero_o = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            bytes_q     <= '0;
            blk_q       <= '0;
            burst_len_q <= '0;
        end else if (load) begin
            bytes_q     <= blk_bytes;
            blk_q       <= blk_bytes;
            burst_len_q <= burst_len;
        end else if (take) begin
            if (last_o && !rpt_zero_o) bytes_q <= blk_q;
            else                       bytes_q <= bytes_q - beat_o;
        end
    end

    // R3: the final beat never exceeds what remains
    a_r3_beat_fits: assert property (@(posedge clk) disable iff (rst)
        take |-> (beat_o <= bytes_q));

endmodule

// File: rtl/dma_trig_seq.sv
module dma_trig_seq
    import dts_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int BURST_W = 8,
    parameter int RPT_W   = 8,
    parameter bit RPT_EN  = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_wr_i,
    input  logic               en_wdata_i,
    input  logic [1:0]         trig_mode_i,
    input  logic [CNT_W-1:0]   blk_bytes_i,
    input  logic [BURST_W-1:0] burst_len_i,
    input  logic [RPT_W-1:0]   rpt_cnt_i,
    input  logic               sw_req_i,
    input  logic               per_req_i,
    input  logic               trig_i,
    input  logic               link_en_i,
    output logic               burst_valid_o,
    input  logic               burst_ready_i,
    output logic [CNT_W-1:0]   burst_bytes_o,
    output logic               link_valid_o,
    input  logic               link_ready_i,
    output logic               done_irq_o,
    output logic               busy_o,
    output logic               trig_ovr_o
);
    seq_state_e state_q;
    chan_cfg_t  cfg_q;
    logic first_blk_q, first_rpt_q, abort_q, irq_q;
    logic start, stop, load, take, last, rpt_zero, pend, consume;
    logic gate, req_ok, issue, link_acc, lgate_go;

    assign start    = (state_q == S_IDLE) && en_wr_i && en_wdata_i;
    assign stop     = en_wr_i && !en_wdata_i;
    assign take     = (state_q == S_BURST) && burst_ready_i;
    assign link_acc = (state_q == S_LINK) && link_ready_i;
    assign load     = start || (link_acc && !abort_q && !stop);
    assign req_ok   = cfg_q.sw || per_req_i;
    assign gate     = gate_needed(cfg_q.mode, RPT_EN, first_blk_q, first_rpt_q);
    assign issue    = (state_q == S_ARM) && !stop && req_ok && (!gate || pend);
    assign lgate_go = (state_q == S_LGATE) && !stop && ((cfg_q.mode != TM_LINK) || pend);
    assign consume  = (issue && gate) || (lgate_go && cfg_q.mode == TM_LINK);

    dts_trig u_trig (
        .clk(clk), .rst(rst), .active(state_q != S_IDLE), .trig_i(trig_i),
        .consume(consume), .clr_ovr(start), .pend_o(pend), .ovr_o(trig_ovr_o)
    );

    dts_count #(.CNT_W(CNT_W), .BURST_W(BURST_W), .RPT_W(RPT_W), .RPT_EN(RPT_EN)) u_count (
        .clk(clk), .rst(rst), .load(load), .blk_bytes(blk_bytes_i),
        .burst_len(burst_len_i), .rpt_cnt(rpt_cnt_i), .take(take),
        .beat_o(burst_bytes_o), .last_o(last), .rpt_zero_o(rpt_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_IDLE;
            cfg_q       <= '0;
            first_blk_q <= 1'b0;
            first_rpt_q <= 1'b0;
            abort_q     <= 1'b0;
            irq_q       <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (load) begin
                cfg_q       <= '{mode: trig_mode_e'(trig_mode_i), sw: sw_req_i};
                first_blk_q <= 1'b1;
                first_rpt_q <= 1'b1;
            end else if (issue) begin
                first_blk_q <= 1'b0;
                first_rpt_q <= 1'b0;
            end else if (take && last && !rpt_zero) begin
                first_blk_q <= 1'b1;
            end
            case (state_q)
                S_IDLE:  if (start) state_q <= S_ARM;
                S_ARM: begin
                    if (stop)       state_q <= S_IDLE;
                    else if (issue) state_q <= S_BURST;
                end
                S_BURST: begin
                    if (stop) abort_q <= 1'b1;
                    if (burst_ready_i) begin
                        if (abort_q || stop)  state_q <= S_IDLE;
                        else if (!last || !rpt_zero) state_q <= S_ARM;
                        else if (link_en_i)   state_q <= S_LGATE;
                        else begin
                            state_q <= S_IDLE;
                            irq_q   <= 1'b1;
                        end
                    end
                end
                S_LGATE: begin
                    if (stop)          state_q <= S_IDLE;
                    else if (lgate_go) state_q <= S_LINK;
                end
                S_LINK: begin
                    if (stop) abort_q <= 1'b1;
                    if (link_ready_i)
                        state_q <= (abort_q || stop) ? S_IDLE : S_ARM;
                end
                default: state_q <= S_IDLE;
            endcase
            if (state_q == S_IDLE) abort_q <= 1'b0;
        end
    end

    assign burst_valid_o = (state_q == S_BURST);
    assign link_valid_o  = (state_q == S_LINK);
    assign busy_o        = (state_q != S_IDLE);
    assign done_irq_o    = irq_q;

    // R2: completion pulse only when idle again, one cycle wide
    a_r2_irq_idle: assert property (@(posedge clk) disable iff (rst)
        done_irq_o |-> !busy_o);
    a_r2_irq_pulse: assert property (@(posedge clk) disable iff (rst)
        done_irq_o |=> !done_irq_o);
    // R3: an offered burst holds its size until accepted
    a_r3_burst_hold: assert property (@(posedge clk) disable iff (rst)
        (burst_valid_o && !burst_ready_i) |=> (burst_valid_o && $stable(burst_bytes_o)));
    // R9: an offered link fetch holds until accepted
    a_r9_link_hold: assert property (@(posedge clk) disable iff (rst)
        (link_valid_o && !link_ready_i) |=> link_valid_o);
    // R11: an aborted channel raises no completion
    a_r11_abort_quiet: assert property (@(posedge clk) disable iff (rst)
        abort_q |=> !done_irq_o);
    // R9: never both handshakes at once
    a_r9_one_handshake: assert property (@(posedge clk) disable iff (rst)
        $onehot0({burst_valid_o, link_valid_o}));

endmodule

// File: tb/dma_trig_seq_bench.sv
module dma_trig_seq_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_wr_i = 0, en_wdata_i = 0, sw_req_i = 0, per_req_i = 0, trig_i = 0, link_en_i = 0;
    logic [1:0] trig_mode_i = 0;
    logic [15:0] blk_bytes_i = 0;
    logic [7:0] burst_len_i = 0, rpt_cnt_i = 0;
    logic burst_ready_i = 1, link_ready_i = 1;
    logic burst_valid_o, link_valid_o, done_irq_o, busy_o, trig_ovr_o;
    logic [15:0] burst_bytes_o;

    int checks = 0, errors = 0;
    int nb = 0, nbytes = 0, last_beat = 0, nl = 0, nirq = 0;

    always #4 clk = ~clk;

    dma_trig_seq u_dma_trig_seq (
        .clk(clk), .rst(rst), .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
        .trig_mode_i(trig_mode_i), .blk_bytes_i(blk_bytes_i), .burst_len_i(burst_len_i),
        .rpt_cnt_i(rpt_cnt_i), .sw_req_i(sw_req_i), .per_req_i(per_req_i), .trig_i(trig_i),
        .link_en_i(link_en_i), .burst_valid_o(burst_valid_o), .burst_ready_i(burst_ready_i),
        .burst_bytes_o(burst_bytes_o), .link_valid_o(link_valid_o), .link_ready_i(link_ready_i),
        .done_irq_o(done_irq_o), .busy_o(busy_o), .trig_ovr_o(trig_ovr_o)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (burst_valid_o && burst_ready_i) begin
                nb <= nb + 1;
                nbytes <= nbytes + int'(burst_bytes_o);
                last_beat <= int'(burst_bytes_o);
            end
            if (link_valid_o && link_ready_i) nl <= nl + 1;
            if (done_irq_o) nirq <= nirq + 1;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_en(logic v);
        @(negedge clk);
        en_wr_i = 1; en_wdata_i = v;
        @(negedge clk);
        en_wr_i = 0;
    endtask

    task automatic start(logic [1:0] m, int bytes, int blen, int rpt, logic sw, logic lnk);
        @(negedge clk);
        trig_mode_i = m; blk_bytes_i = 16'(bytes); burst_len_i = 8'(blen);
        rpt_cnt_i = 8'(rpt); sw_req_i = sw; link_en_i = lnk;
        write_en(1'b1);
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig_i = 1;
        @(negedge clk); trig_i = 0;
    endtask

    task automatic t_reset();
        chk("R1 busy after reset", int'(busy_o), 0);
        chk("R1 burst_valid after reset", int'(burst_valid_o), 0);
        chk("R1 link_valid after reset", int'(link_valid_o), 0);
        chk("R1 irq/ovr after reset", int'(done_irq_o | trig_ovr_o), 0);
    endtask

    task automatic t_block_mode();
        int b0 = nb, s0 = nbytes, i0 = nirq;
        per_req_i = 1;
        start(2'b00, 16, 4, 0, 0, 0);
        chk("R1 busy after enable", int'(busy_o), 1);
        cyc(10);
        chk("R4 no burst before hit", nb - b0, 0);
        pulse_trig(); cyc(20);
        chk("R4 whole block after one hit", nb - b0, 4);
        chk("R3 block byte total", nbytes - s0, 16);
        chk("R2 one completion", nirq - i0, 1);
        chk("R2 idle after completion", int'(busy_o), 0);
    endtask

    task automatic t_remainder();
        int b0 = nb, s0 = nbytes;
        per_req_i = 1;
        start(2'b10, 10, 4, 0, 0, 0);
        cyc(20);
        chk("R3 beats for 10 bytes", nb - b0, 3);
        chk("R3 total bytes", nbytes - s0, 10);
        chk("R3 short final beat", last_beat, 2);
        chk("R6 ungated bursts done", int'(busy_o), 0);
    endtask

    task automatic t_rpt_block();
        int b0 = nb, i0 = nirq;
        per_req_i = 1;
        start(2'b00, 8, 4, 2, 0, 0);
        pulse_trig(); cyc(20);
        chk("R4 first block only", nb - b0, 2);
        chk("R4 waiting for next hit", int'(busy_o), 1);
        pulse_trig(); cyc(20);
        chk("R4 second block", nb - b0, 4);
        pulse_trig(); cyc(20);
        chk("R4 third block", nb - b0, 6);
        chk("R4 done after N+1 blocks", nirq - i0, 1);
    endtask

    task automatic t_rpt_whole();
        int b0 = nb;
        per_req_i = 1;
        start(2'b01, 8, 4, 2, 0, 0);
        cyc(10);
        chk("R5 gated before hit", nb - b0, 0);
        pulse_trig(); cyc(30);
        chk("R5 all repetitions on one hit", nb - b0, 6);
        chk("R5 idle", int'(busy_o), 0);
    endtask

    task automatic t_burst_mode();
        int b0 = nb;
        per_req_i = 0;
        start(2'b11, 8, 4, 0, 0, 0);
        pulse_trig(); cyc(10);
        chk("R8 no request no burst", nb - b0, 0);
        per_req_i = 1; cyc(6);
        chk("R7 pending hit plus request", nb - b0, 1);
        cyc(10);
        chk("R7 second burst waits for hit", nb - b0, 1);
        pulse_trig(); cyc(10);
        chk("R7 second burst after hit", nb - b0, 2);
        chk("R7 done", int'(busy_o), 0);
    endtask

    task automatic t_sw_mode();
        int b0 = nb;
        per_req_i = 0;
        start(2'b11, 8, 4, 0, 1, 0);
        cyc(8);
        chk("R7 sw flag still waits for hit", nb - b0, 0);
        pulse_trig(); cyc(8);
        chk("R7 sw one burst per hit", nb - b0, 1);
        pulse_trig(); cyc(8);
        chk("R7 sw second burst", nb - b0, 2);
    endtask

    task automatic t_level();
        int b0 = nb;
        per_req_i = 1;
        start(2'b11, 8, 4, 0, 0, 0);
        @(negedge clk); trig_i = 1;
        cyc(12); trig_i = 0; cyc(2);
        chk("R10 held level is one hit", nb - b0, 1);
        pulse_trig(); cyc(8);
        chk("R10 new edge new hit", nb - b0, 2);
    endtask

    task automatic t_link();
        int b0 = nb, s0 = nbytes, l0 = nl, i0 = nirq;
        per_req_i = 1;
        start(2'b10, 8, 4, 0, 0, 1);
        cyc(20);
        chk("R6 data bursts ungated", nb - b0, 2);
        chk("R6 link waits for hit", nl - l0, 0);
        chk("R6 link not offered", int'(link_valid_o), 0);
        link_en_i = 0; blk_bytes_i = 12;
        pulse_trig(); cyc(20);
        chk("R9 one link fetch", nl - l0, 1);
        chk("R9 reloaded block bursts", nb - b0, 5);
        chk("R9 reloaded byte total", nbytes - s0, 20);
        chk("R2 completion after link", nirq - i0, 1);
    endtask

    task automatic t_overrun();
        per_req_i = 0;
        start(2'b11, 8, 4, 0, 0, 0);
        pulse_trig(); cyc(2); pulse_trig(); cyc(2);
        chk("R10 overrun set", int'(trig_ovr_o), 1);
        cyc(3);
        chk("R10 overrun sticky", int'(trig_ovr_o), 1);
        write_en(1'b0); cyc(1);
        chk("R11 idle at once without handshake", int'(busy_o), 0);
        start(2'b11, 8, 4, 0, 0, 0);
        chk("R10 overrun cleared on start", int'(trig_ovr_o), 0);
        write_en(1'b0); cyc(1);
    endtask

    task automatic t_abort();
        int b0 = nb, i0 = nirq;
        per_req_i = 1; burst_ready_i = 0;
        start(2'b10, 8, 4, 0, 0, 0);
        cyc(4);
        chk("R11 burst outstanding", int'(burst_valid_o), 1);
        write_en(1'b0); cyc(3);
        chk("R11 burst held after disable", int'(burst_valid_o), 1);
        chk("R11 still busy", int'(busy_o), 1);
        burst_ready_i = 1; cyc(4);
        chk("R11 idle after burst", int'(busy_o), 0);
        chk("R11 burst finished", nb - b0, 1);
        chk("R11 no completion", nirq - i0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_block_mode();
        t_remainder();
        t_rpt_block();
        t_rpt_whole();
        t_burst_mode();
        t_sw_mode();
        t_level();
        t_link();
        t_overrun();
        t_abort();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule